// File: doc/BRIEF.md
# Complementary PWM Pair with Deadband

This block turns the count of a shared up-counting PWM timer into two gate-drive outputs, a high side and a low side. Each system clock it compares the timer count with a duty value. It picks which output is in its on-state for the current part of the period. A polarity input swaps which output starts the period on. The duty value is captured only when the timer marks the start of a period, so a change written mid-period never causes a glitch.

In complementary mode, every time the pair changes phase the block holds both outputs off for a programmable number of system clocks before it turns on the incoming side. This gap counts raw system clocks, however slowly the timer count advances. It is cut from the incoming side's active time, and the period stays the same. In independent mode the two outputs follow the comparison with no gap. In either mode, a global force enable together with a per-output bit drives one output to its off-state while the other keeps running.

Top module: `pwmpair_db`

## Requirements
- R1: With `cmp_mode`=0 and `pol_inv`=0, `drv_hi` is 1 while `tmr_cnt` < the captured duty value and `drv_lo` is 1 otherwise, with no gap. Both outputs are registered and reflect the inputs one system clock later.
- R2: With `pol_inv`=1 the starting states swap: `drv_hi` is 1 when `tmr_cnt` >= duty, and `drv_lo` is 1 while `tmr_cnt` < duty.
- R3: With `cmp_mode`=1, on every change of phase both outputs go to 0 for exactly `dead_len` system clocks, and then the incoming side turns on. The period does not change.
- R4: The deadband is counted in system clocks, independent of how many clocks the timer holds each count value.
- R5: With `cmp_mode`=1 and `dead_len`=0, one output turns off and the other turns on at the same clock edge.
- R6: If a phase lasts fewer system clocks than `dead_len`, its incoming output stays 0 for the whole phase, and the deadband restarts at the next phase change.
- R7: With `cmp_mode`=1, `drv_hi` and `drv_lo` are never 1 together.
- R8: `off_en`=1 with `off_hi`=1 forces `drv_hi` to 0 from the next clock while `drv_lo` continues normally. `off_lo` does the same for `drv_lo`.
- R9: With `off_en`=0, the `off_hi` and `off_lo` bits have no effect on either output.
- R10: `duty` is captured only in a cycle with `prd_start`=1, and that cycle already uses the new value. A change of `duty` in any other cycle does not affect the outputs until the next period start.
- R11: While `rst_n` is 0, both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_cnt | input | CW | Current count of the shared PWM timer |
| prd_start | input | 1 | One-clock pulse in the first cycle of a period (count 0) |
| duty | input | CW | Duty comparison value |
| pol_inv | input | 1 | 1 = high side starts the period off, low side on |
| cmp_mode | input | 1 | 1 = complementary with deadband, 0 = independent |
| dead_len | input | DBW | Deadband length in system clocks (0..255 by default) |
| off_en | input | 1 | Global enable for manual off-state forcing |
| off_hi | input | 1 | Force high side off when `off_en` is 1 |
| off_lo | input | 1 | Force low side off when `off_en` is 1 |
| drv_hi | output | 1 | High-side gate drive, 1 = on |
| drv_lo | output | 1 | Low-side gate drive, 1 = on |

## Verification
The hardest case to reach from the ports is a phase shorter than the deadband. Here a second phase change arrives while the gap counter is still running, and the counter must restart without ever letting the incoming side on. The stimulus reaches it with duty values one or two counts from either end of the period, a deadband longer than those phases, and an undivided timer. A second hard case is a duty write that lands mid-period. The random phase changes `duty` on arbitrary clocks, and the expected outputs use only the value present at each period start. Other phases slow the timer with a prescale so that the deadband spans several clocks per count.

// File: rtl/pwmpair_pkg.sv
package pwmpair_pkg;
  typedef enum logic {
    PAIR_INDEP = 1'b0,
    PAIR_COMP  = 1'b1
  } pair_mode_e;

  typedef struct packed {
    logic hi;
    logic lo;
  } drv_pair_t;
endpackage

// File: rtl/pwmpair_phase.sv
module pwmpair_phase #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] tmr_cnt,
  input  logic          prd_start,
  input  logic [CW-1:0] duty,
  input  logic          pol_inv,
  output logic          hi_phase
);
  logic [CW-1:0] duty_q;
  logic [CW-1:0] duty_eff;

  // high side owns the first part of the period unless polarity swaps it
  function automatic logic hi_owns(input logic [CW-1:0] cnt,
                                   input logic [CW-1:0] dv,
                                   input logic          inv);
    return (cnt < dv) ^ inv;
  endfunction

  assign duty_eff = prd_start ? duty : duty_q;
  assign hi_phase = hi_owns(tmr_cnt, duty_eff, pol_inv);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         duty_q <= '0;
    else if (prd_start) duty_q <= duty;
  end
endmodule

// File: rtl/pwmpair_dead.sv
module pwmpair_dead #(
  parameter int DBW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           hi_phase,
  input  logic [DBW-1:0] dead_len,
  output logic           flip,
  output logic           dead_idle
);
  logic           phase_q;
  logic [DBW-1:0] dcnt;
  logic [DBW-1:0] dcnt_nx;

  function automatic logic [DBW-1:0] dead_next(input logic           chg,
                                               input logic [DBW-1:0] len,
                                               input logic [DBW-1:0] cur);
    if (chg)           return len;
    else if (cur != 0) return cur - DBW'(1);
    else               return '0;
  endfunction

  assign flip      = hi_phase != phase_q;
  assign dcnt_nx   = dead_next(flip, dead_len, dcnt);
  assign dead_idle = dcnt_nx == '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      dcnt    <= '0;
    end else begin
      phase_q <= hi_phase;
      dcnt    <= dcnt_nx;
    end
  end
endmodule

// File: rtl/pwmpair_gate.sv
module pwmpair_gate
  import pwmpair_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  pair_mode_e mode,
  input  logic       hi_phase,
  input  logic       dead_idle,
  input  logic       off_en,
  input  logic       off_hi,
  input  logic       off_lo,
  output drv_pair_t  drv
);
  drv_pair_t want;

  always_comb begin
    if (mode == PAIR_COMP) begin
      want.hi = hi_phase & dead_idle;
      want.lo = ~hi_phase & dead_idle;
    end else begin
      want.hi = hi_phase;
      want.lo = ~hi_phase;
    end
    if (off_en && off_hi) want.hi = 1'b0;
    if (off_en && off_lo) want.lo = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drv <= '0;
    else        drv <= want;
  end
endmodule

// File: rtl/pwmpair_db.sv
module pwmpair_db
  import pwmpair_pkg::*;
#(
  parameter int CW  = 8,
  parameter int DBW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [CW-1:0]  tmr_cnt,
  input  logic           prd_start,
  input  logic [CW-1:0]  duty,
  input  logic           pol_inv,
  input  logic           cmp_mode,
  input  logic [DBW-1:0] dead_len,
  input  logic           off_en,
  input  logic           off_hi,
  input  logic           off_lo,
  output logic           drv_hi,
  output logic           drv_lo
);
  logic       hi_phase;
  logic       flip;
  logic       dead_idle;
  pair_mode_e mode;
  drv_pair_t  drv;

  assign mode = cmp_mode ? PAIR_COMP : PAIR_INDEP;

  pwmpair_phase #(.CW(CW)) u_phase (
    .clk(clk), .rst_n(rst_n), .tmr_cnt(tmr_cnt), .prd_start(prd_start),
    .duty(duty), .pol_inv(pol_inv), .hi_phase(hi_phase)
  );

  pwmpair_dead #(.DBW(DBW)) u_dead (
    .clk(clk), .rst_n(rst_n), .hi_phase(hi_phase), .dead_len(dead_len),
    .flip(flip), .dead_idle(dead_idle)
  );

  pwmpair_gate u_gate (
    .clk(clk), .rst_n(rst_n), .mode(mode), .hi_phase(hi_phase),
    .dead_idle(dead_idle), .off_en(off_en), .off_hi(off_hi),
    .off_lo(off_lo), .drv(drv)
  );

  assign drv_hi = drv.hi;
  assign drv_lo = drv.lo;
endmodule

// File: rtl/pwmpair_db_chk.sv
module pwmpair_db_chk #(
  parameter int DBW = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cmp_mode,
  input logic [DBW-1:0] dead_len,
  input logic           off_en,
  input logic           off_hi,
  input logic           off_lo,
  input logic           flip,
  input logic           drv_hi,
  input logic           drv_lo
);
  p_indep_comp_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmp_mode && !off_en) |=> (drv_hi != drv_lo));

  p_gap_both_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_mode && flip && dead_len != '0) |=> (!drv_hi && !drv_lo));

  p_zero_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_mode && flip && dead_len == '0 && !off_en) |=> (drv_hi != drv_lo));

  p_no_overlap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_mode |=> !(drv_hi && drv_lo));

  p_force_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (off_en && off_hi) |=> !drv_hi);

  p_force_lo_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (off_en && off_lo) |=> !drv_lo);
endmodule

bind pwmpair_db pwmpair_db_chk #(.DBW(DBW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmp_mode(cmp_mode), .dead_len(dead_len),
  .off_en(off_en), .off_hi(off_hi), .off_lo(off_lo), .flip(flip),
  .drv_hi(drv_hi), .drv_lo(drv_lo)
);

// File: tb/pwmpair_db_tb.sv
module pwmpair_db_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CW  = 8;
  localparam int DBW = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [CW-1:0]  tmr_cnt = '0;
  logic           prd_start = 1'b0;
  logic [CW-1:0]  duty = '0;
  logic           pol_inv = 1'b0;
  logic           cmp_mode = 1'b0;
  logic [DBW-1:0] dead_len = '0;
  logic           off_en = 1'b0;
  logic           off_hi = 1'b0;
  logic           off_lo = 1'b0;
  logic           drv_hi;
  logic           drv_lo;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  // reference state kept by the bench
  logic           m_side;
  int             m_gap;
  logic [CW-1:0]  m_duty;
  logic           e_hi, e_lo;
  // timer generator
  int psc = 1, pre = 0, per = 32;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwmpair_db #(.CW(CW), .DBW(DBW)) u_dut (
    .clk(clk), .rst_n(rst_n), .tmr_cnt(tmr_cnt), .prd_start(prd_start),
    .duty(duty), .pol_inv(pol_inv), .cmp_mode(cmp_mode), .dead_len(dead_len),
    .off_en(off_en), .off_hi(off_hi), .off_lo(off_lo),
    .drv_hi(drv_hi), .drv_lo(drv_lo)
  );

  task automatic check(input string req, input logic act, input logic exp, input string what);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  // which side owns the phase, stated from the duty rule
  function automatic logic side_of(input int cnt, input int dv, input logic inv);
    logic early;
    early = cnt < dv;
    return inv ? !early : early;
  endfunction

  // expected result of one clock edge
  task automatic model_edge();
    int dv;
    logic s;
    dv = prd_start ? int'(duty) : int'(m_duty);
    if (prd_start) m_duty = duty;
    s = side_of(int'(tmr_cnt), dv, pol_inv);
    if (s != m_side) m_gap = int'(dead_len);
    else if (m_gap > 0) m_gap = m_gap - 1;
    m_side = s;
    if (cmp_mode) begin
      e_hi = s && (m_gap == 0);
      e_lo = !s && (m_gap == 0);
    end else begin
      e_hi = s;
      e_lo = !s;
    end
    if (off_en && off_hi) e_hi = 1'b0;
    if (off_en && off_lo) e_lo = 1'b0;
  endtask

  // one system clock: edge, check at the falling edge, advance the timer
  task automatic tick(input string req);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(req, drv_hi, e_hi, "drv_hi");
    check(req, drv_lo, e_lo, "drv_lo");
    if (cmp_mode) check("R7", drv_hi && drv_lo, 1'b0, "overlap");
    pre++;
    prd_start = 1'b0;
    if (pre >= psc) begin
      pre = 0;
      tmr_cnt = (int'(tmr_cnt) >= per - 1) ? '0 : tmr_cnt + 1'b1;
      prd_start = (tmr_cnt == '0);
    end
  endtask

  task automatic run(input string req, input int n, input int dv_lo, input int dv_hi,
                     input bit duty_jitter);
    for (int i = 0; i < n; i++) begin
      if (duty_jitter && ($urandom % 7 == 0))
        duty = CW'(dv_lo + ($urandom % (dv_hi - dv_lo + 1)));
      tick(req);
    end
  endtask

  initial begin
    void'($urandom(32'd2718));
    m_side = 1'b0; m_gap = 0; m_duty = '0; e_hi = 0; e_lo = 0;
    // R11: reset state
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R11", drv_hi, 1'b0, "drv_hi in reset");
    check("R11", drv_lo, 1'b0, "drv_lo in reset");
    rst_n = 1'b1;
    prd_start = 1'b1;
    duty = 8'd12;

    // R1: independent, polarity clear
    run("R1", 300, 0, per, 1);
    // R2: polarity set
    pol_inv = 1'b1;
    run("R2", 300, 0, per, 1);
    pol_inv = 1'b0;
    // R3: complementary deadband, undivided timer
    cmp_mode = 1'b1; dead_len = 8'd5;
    run("R3", 400, 4, per - 4, 1);
    // R4: slow timer, deadband still counted in system clocks
    psc = 4; dead_len = 8'd6;
    run("R4", 600, 2, per - 2, 1);
    psc = 1;
    // R5: zero deadband
    dead_len = 8'd0;
    run("R5", 200, 1, per - 1, 1);
    // R6: phases shorter than the deadband
    dead_len = 8'd30; per = 40;
    duty = 8'd2;
    run("R6", 200, 2, 2, 0);
    duty = 8'd39;
    run("R6", 200, 39, 39, 0);
    duty = 8'd1; pol_inv = 1'b1;
    run("R6", 200, 1, 1, 0);
    pol_inv = 1'b0; per = 32;
    // R8: forced off, partner keeps running
    dead_len = 8'd3; off_en = 1'b1; off_hi = 1'b1;
    run("R8", 200, 4, 28, 1);
    off_hi = 1'b0; off_lo = 1'b1;
    run("R8", 200, 4, 28, 1);
    cmp_mode = 1'b0;
    run("R8", 200, 4, 28, 1);
    // R9: off bits without the global enable
    off_en = 1'b0; off_hi = 1'b1; off_lo = 1'b1;
    run("R9", 200, 0, per, 1);
    cmp_mode = 1'b1;
    run("R9", 200, 4, 28, 1);
    off_hi = 1'b0; off_lo = 1'b0;
    // R10: duty changing on every clock, random settings
    for (int k = 0; k < 6; k++) begin
      psc = 1 + ($urandom % 3);
      pol_inv = 1'($urandom);
      cmp_mode = 1'($urandom);
      dead_len = DBW'($urandom % 12);
      for (int i = 0; i < 250; i++) begin
        duty = CW'($urandom % (per + 1));
        tick("R10");
      end
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule